// File: doc/BRIEF.md
# Memory Image Checksum Engine

This block computes a 16-bit checksum over the image of a small program memory. A caller pulses a start strobe with the configuration word and four user identification words on its inputs. With the protection bit clear, the block loads a masked copy of the configuration word. It then adds each 14-bit program word the caller presents on a word-valid stream until it has accepted 2048 of them. With the protection bit set, the block adds no program words. It forms the result at once from the masked configuration word and a 16-bit value built from the low nibbles of the four ID words.

All arithmetic is modulo 2^16. A done flag marks the result as final, and the result stays on the output until the next start.

The controller is a three-state machine:
- `ST_IDLE` is the state after reset.
- `ST_STREAM` accepts program words.
- `ST_DONE` holds the result.

Its transitions are:
- IDLE→STREAM on start with protection off.
- IDLE→DONE on start with protection on.
- STREAM→DONE when the 2048th word is accepted.
- STREAM→STREAM or DONE→STREAM on a restart with protection off.
- STREAM→DONE or DONE→DONE on a restart with protection on.

Top module: `img_csum_top`

## Requirements
- R1: The checksum is 16 bits wide, and every carry out of bit 15 is discarded.
- R2: With protection off, the result is the sum of the 2048 accepted program words plus (configuration word AND 0x0FFF).
- R3: Protection is taken from bit 6 of `cfg_word_i` at the start strobe, where 0 means protected. When protected, program words presented afterwards do not change the result.
- R4: When protected, the result is (configuration word AND 0x0FFF) plus a packed ID value. The ID words are supplied as ID k in bits [14k+13:14k] of `id_words_i`. The packed value holds the low nibble of ID 0 in bits 15:12, ID 1 in bits 11:8, ID 2 in bits 7:4 and ID 3 in bits 3:0.
- R5: A blank unprotected image, with every program word and the configuration word equal to 0x3FFF, yields 0x07FF.
- R6: With protection off, `done_o` is low while words are streaming. It goes high in the cycle after the clock edge that accepts the 2048th word.
- R7: With protection on, `done_o` is high in the cycle after the clock edge that samples the start strobe.
- R8: A start strobe clears the accumulator, drops `done_o` and restarts the count, even in the middle of a stream. A valid word in the same cycle as start is not added.
- R9: Once `done_o` is high, further word-valid pulses are ignored and the result holds.
- R10: After reset, `done_o` is low and `sum_o` is 0. Word-valid pulses before the first start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; samples configuration and ID words |
| cfg_word_i | input | 14 | Configuration word; bit 6 low selects protected mode |
| id_words_i | input | 56 | Four ID words, ID k in bits [14k+13:14k] |
| word_valid_i | input | 1 | Program word on `word_i` is valid this cycle |
| word_i | input | 14 | Program word, presented in address order |
| sum_o | output | 16 | Checksum result / running accumulator |
| done_o | output | 1 | Result is final |

## Verification
The bench covers the following corner cases:
- **Nibble packing.** It drives protected cases with distinctive, asymmetric ID nibbles, so a swapped packing order or a nibble taken from the wrong field changes the sum.
- **Wrap-around.** It uses sums that carry out of bit 15, so a design that saturates or widens the result is caught.
- **Done timing.** It checks `done_o` just before and just after the 2048th word. An off-by-one counter would raise done a word early, or raise it late and add a 2049th word.
- **Restart and late words.** It restarts mid-stream with a coincident valid word and presents words after done. A design that keeps stale sums, adds that word, or accepts words past the limit gives a wrong final value.

// File: rtl/img_csum_pkg.sv
package img_csum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DONE   = 2'd2
    } csum_state_e;

endpackage

// File: rtl/img_csum_idpack.sv
module img_csum_idpack #(
    parameter int WORD_W  = 14,
    parameter int NUM_IDS = 4,
    parameter int NIB_W   = 4,
    localparam int PACK_W = NUM_IDS * NIB_W
) (
    input  logic [NUM_IDS*WORD_W-1:0] id_words_i,
    output logic [PACK_W-1:0]         packed_o
);

    // ID 0 lands in the most significant nibble, the last ID in the least.
    for (genvar k = 0; k < NUM_IDS; k++) begin : g_nib
        assign packed_o[(NUM_IDS-1-k)*NIB_W +: NIB_W] =
            NIB_W'(id_words_i[k*WORD_W +: WORD_W]);
    end

endmodule

// File: rtl/img_csum_ctrl.sv
module img_csum_ctrl
    import img_csum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic prot_i,
    input  logic valid_i,
    input  logic last_i,
    output logic load_o,
    output logic accept_o,
    output logic done_o
);

    csum_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = prot_i ? ST_DONE : ST_STREAM;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_STREAM: if (valid_i && last_i) state_d = ST_DONE;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_o   = start_i;
        accept_o = (state_q == ST_STREAM) && valid_i && !start_i;
        done_o   = (state_q == ST_DONE);
    end

    // R6: accepting the final word makes the result final next cycle
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && last_i) |=> done_o);

    // R7: a protected start finishes in one cycle
    p_prot_start_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && prot_i) |=> done_o);

    // R8: an unprotected start always reopens the stream
    p_restart_clears_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !prot_i) |=> !done_o);

    // R9: no word is taken once the result is final
    p_no_accept_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !accept_o);

endmodule

// File: rtl/img_csum_accum.sv
module img_csum_accum #(
    parameter int WORD_W    = 14,
    parameter int SUM_W     = 16,
    parameter int NUM_WORDS = 2048,
    localparam int CNT_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SUM_W-1:0]  load_val_i,
    input  logic              accept_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [SUM_W-1:0]  acc_o,
    output logic              last_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_WORDS - 1);

    logic [SUM_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;

    // The sum is kept at SUM_W bits; carries past the top bit fall away.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            acc_q <= load_val_i;
            cnt_q <= '0;
        end else if (accept_i) begin
            acc_q <= acc_q + SUM_W'(word_i);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign acc_o  = acc_q;
    assign last_o = (cnt_q == CNT_LAST);

    // R8: start loads the seed value
    p_load_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (acc_q == $past(load_val_i)));

    // R9: without load or accept the accumulator holds
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !accept_i) |=> $stable(acc_q));

    // R1: each accepted word adds modulo 2^SUM_W
    p_wrap_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !load_i) |=> (acc_q == $past(acc_q) + SUM_W'($past(word_i))));

endmodule

// File: rtl/img_csum_top.sv
module img_csum_top
    import img_csum_pkg::*;
#(
    parameter int WORD_W    = 14,
    parameter int SUM_W     = 16,
    parameter int NUM_WORDS = 2048,
    parameter int NUM_IDS   = 4,
    parameter int NIB_W     = 4,
    parameter int PROT_BIT  = 6,
    parameter int CFG_KEEP  = 12,
    localparam int IDS_W    = NUM_IDS * WORD_W,
    localparam int PACK_W   = NUM_IDS * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    input  logic [IDS_W-1:0]  id_words_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [SUM_W-1:0]  sum_o,
    output logic              done_o
);

    localparam logic [WORD_W-1:0] CFG_MASK = WORD_W'((1 << CFG_KEEP) - 1);

    logic              prot;
    logic [SUM_W-1:0]  cfg_term;
    logic [PACK_W-1:0] id_packed;
    logic [SUM_W-1:0]  seed;
    logic              load, accept, last;

    assign prot     = ~cfg_word_i[PROT_BIT];
    assign cfg_term = SUM_W'(cfg_word_i & CFG_MASK);
    assign seed     = prot ? (cfg_term + SUM_W'(id_packed)) : cfg_term;

    img_csum_idpack #(
        .WORD_W (WORD_W),
        .NUM_IDS(NUM_IDS),
        .NIB_W  (NIB_W)
    ) u_pack (
        .id_words_i(id_words_i),
        .packed_o  (id_packed)
    );

    img_csum_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .prot_i  (prot),
        .valid_i (word_valid_i),
        .last_i  (last),
        .load_o  (load),
        .accept_o(accept),
        .done_o  (done_o)
    );

    img_csum_accum #(
        .WORD_W   (WORD_W),
        .SUM_W    (SUM_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_val_i(seed),
        .accept_i  (accept),
        .word_i    (word_i),
        .acc_o     (sum_o),
        .last_o    (last)
    );

    // R4: protected result is the masked configuration word plus packed IDs
    p_prot_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !cfg_word_i[PROT_BIT]) |=>
            (sum_o == SUM_W'($past(cfg_word_i) & CFG_MASK) + SUM_W'($past(id_packed))));

    // R3: in protected mode streamed words leave the result alone
    p_prot_ignores_words_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i && word_valid_i) |=> $stable(sum_o));

endmodule

// File: tb/img_csum_top_test.sv
module img_csum_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [13:0] cfg_word_i = '0;
    logic [55:0] id_words_i = '0;
    logic        word_valid_i = 1'b0;
    logic [13:0] word_i = '0;
    logic [15:0] sum_o;
    logic        done_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    img_csum_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cfg_word_i  (cfg_word_i),
        .id_words_i  (id_words_i),
        .word_valid_i(word_valid_i),
        .word_i      (word_i),
        .sum_o       (sum_o),
        .done_o      (done_o)
    );

    // {cfg, id3, id2, id1, id0, expected} for protected starts (R4, R1)
    localparam int NV = 4;
    localparam logic [85:0] VEC [NV] = '{
        {14'h3FBF, 14'h0004, 14'h0003, 14'h0002, 14'h0001, 16'h21F3},
        {14'h0000, 14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3FFF, 16'hFFFF},
        {14'h0FBF, 14'h000F, 14'h000F, 14'h000F, 14'h000F, 16'h0FBE},
        {14'h30A5, 14'h0007, 14'h002C, 14'h0015, 14'h03FA, 16'hA66C}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic [13:0] cfg, input logic [55:0] ids,
                            input logic v, input logic [13:0] w);
        @(negedge clk);
        start_i = 1'b1; cfg_word_i = cfg; id_words_i = ids;
        word_valid_i = v; word_i = w;
        @(negedge clk);
        start_i = 1'b0; word_valid_i = 1'b0;
    endtask

    // Streams n words (n<=2048); returns the model sum of the words fed.
    task automatic feed(input int mode, input int n, input int gap,
                        input logic [15:0] seed, output logic [15:0] model);
        model = seed;
        for (int i = 0; i < n; i++) begin
            logic [13:0] w;
            w = (mode == 0) ? 14'h3FFF : 14'(i * 37 + 5);
            if (gap != 0 && (i % 5) == 0) begin
                word_valid_i = 1'b0;
                @(negedge clk);
            end
            if (i == 2047) check("R6 done low before last word", 32'(done_o), 32'd0);
            word_valid_i = 1'b1; word_i = w;
            model = model + 16'(w);
            @(negedge clk);
        end
        word_valid_i = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] model;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset done", 32'(done_o), 32'd0);
        check("R10 reset sum", 32'(sum_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        word_valid_i = 1'b1; word_i = 14'h1234;
        repeat (3) @(negedge clk);
        word_valid_i = 1'b0;
        check("R10 idle words ignored", 32'(sum_o), 32'd0);
        check("R10 idle done low", 32'(done_o), 32'd0);

        // Vector table: protected starts (R4, R7, R1)
        for (int v = 0; v < NV; v++) begin
            do_start(VEC[v][85:72], VEC[v][71:16], 1'b0, 14'h0);
            check("R7 protected done next cycle", 32'(done_o), 32'd1);
            check("R4 protected sum", 32'(sum_o), 32'(VEC[v][15:0]));
        end

        // R3: words after a protected start are not added
        word_valid_i = 1'b1; word_i = 14'h2222;
        repeat (4) @(negedge clk);
        word_valid_i = 1'b0;
        check("R3 protected ignores words", 32'(sum_o), 32'(VEC[NV-1][15:0]));

        // R2, R6: unprotected stream with gaps and a wrapping sum (R1)
        do_start(14'h1FC3, 56'h0, 1'b0, 14'h0);
        check("R8 restart drops done", 32'(done_o), 32'd0);
        check("R8 seed is masked cfg", 32'(sum_o), 32'h0FC3);
        feed(1, 2048, 1, 16'h0FC3, model);
        check("R6 done after last word", 32'(done_o), 32'd1);
        check("R2 unprotected sum", 32'(sum_o), 32'(model));

        // R9: words after done are ignored
        word_valid_i = 1'b1; word_i = 14'h3FFF;
        repeat (5) @(negedge clk);
        word_valid_i = 1'b0;
        check("R9 sum holds after done", 32'(sum_o), 32'(model));
        check("R9 done holds", 32'(done_o), 32'd1);

        // R8: restart mid-stream with a coincident valid word
        do_start(14'h3FFF, 56'h0, 1'b0, 14'h0);
        feed(1, 100, 0, 16'h0FFF, model);
        check("R6 done low mid stream", 32'(done_o), 32'd0);
        do_start(14'h3FFF, 56'h0, 1'b1, 14'h3FFF);
        check("R8 coincident word not added", 32'(sum_o), 32'h0FFF);
        check("R8 done low after restart", 32'(done_o), 32'd0);

        // R5: blank image
        feed(0, 2048, 0, 16'h0FFF, model);
        check("R5 blank image sum", 32'(sum_o), 32'h07FF);
        check("R5 model agrees", 32'(model), 32'h07FF);
        check("R6 done after blank image", 32'(done_o), 32'd1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule